// File: doc/BRIEF.md
# I2C bus recovery sequencer

This block frees an I2C bus that a slave holds stuck with SDA low, for example after a reset in the middle of a read. When the controller has been set up for a new transfer and SDA is still low, the `start` input is pulsed. The block then takes over both open-drain pads from the normal I2C engine and plays out a fixed line-level script. First it runs a train of nine SCL clock pulses with SDA released. Then it forms a STOP condition in four steps.

Each step of the script is held for a programmable number of clock cycles. That number is about half an SCL period. At the end, `done` pulses for one cycle. `bus_stuck` reports whether SDA was still low at the end, so that the caller can abort the transfer with a bus-busy error. Outside a recovery, the pad drives come straight from the engine.

Pad drives are active-high pull-down enables: a 1 drives the line low, and a 0 releases it high.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, `busy`, `done` and `bus_stuck` are low, and the pad drives follow the engine inputs.
- R2: While `busy` is low, `scl_pull` equals `eng_scl_oe` and `sda_pull` equals `eng_sda_oe`.
- R3: A `start` seen at a clock edge while idle raises `busy` after that edge. `half_period` is captured at that edge as H, with 0 treated as 1. `busy` then stays high for exactly 22*H cycles, which is 22 steps of H cycles each.
- R4: Steps 0 to 17 form the pulse train. In even steps SCL is released high, and in odd steps SCL is driven low. SDA is released in all of them, so SCL falls exactly 9 times.
- R5: Steps 18 to 21 form the STOP, with (SCL, SDA) levels of (low, high), then (low, low), then (high, low), then (high, high).
- R6: `done` is high for exactly one cycle. It rises at the same edge at which `busy` falls.
- R7: A `start` that arrives while `busy` is high is ignored. The running sequence keeps its length and ends normally.
- R8: `bus_stuck` is set to the inverse of `sda_in`, sampled at the end of step 21. It holds that value until the next accepted `start`, which clears it.
- R9: While `busy` is high, the engine inputs have no effect on the pad drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Recovery trigger, sampled at the clock edge |
| half_period | input | HPW | Cycles per line-level step (0 acts as 1) |
| eng_scl_oe | input | 1 | SCL pull-down request from the normal engine |
| eng_sda_oe | input | 1 | SDA pull-down request from the normal engine |
| sda_in | input | 1 | Sampled SDA pad level |
| scl_pull | output | 1 | SCL pad pull-down enable |
| sda_pull | output | 1 | SDA pad pull-down enable |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle pulse at the end of recovery |
| bus_stuck | output | 1 | SDA was still low at the end of the last recovery |

## Verification
Suppose the step counter or the cycle counter took a wrong value. The pad levels would then leave the expected script within one step of H cycles, and the overall `busy` length would differ from 22*H. The bench therefore compares every cycle's line levels against the step index derived from elapsed time. Suppose instead that the capture of `half_period` was lost. Then the step lengths would follow later changes of that input, and the total length check would catch it. A wrong end condition shows up as a missing or doubled `done`, or as a wrong `bus_stuck`, in the cycle right after `busy` falls.

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int HPW    = 16,
  parameter int PULSES = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [HPW-1:0] half_period,
  input  logic           eng_scl_oe,
  input  logic           eng_sda_oe,
  input  logic           sda_in,
  output logic           scl_pull,
  output logic           sda_pull,
  output logic           busy,
  output logic           done,
  output logic           bus_stuck
);
  localparam int STEPS = 2 * PULSES + 4;
  localparam int SW    = $clog2(STEPS);
  localparam logic [SW-1:0] TRAIN_END = SW'(2 * PULSES);
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  logic [SW-1:0]  step;
  logic [HPW-1:0] cnt, hp_q;
  logic           busy_q, done_q, stuck_q;

  wire step_end = (cnt == hp_q - HPW'(1));
  wire last     = (step == LAST_STEP);
  wire in_train = (step < TRAIN_END);
  wire scl_lvl  = in_train ? ~step[0] : (step >= TRAIN_END + SW'(2));
  wire sda_lvl  = in_train | (step == TRAIN_END) | last;

  assign scl_pull  = busy_q ? ~scl_lvl : eng_scl_oe;
  assign sda_pull  = busy_q ? ~sda_lvl : eng_sda_oe;
  assign busy      = busy_q;
  assign done      = done_q;
  assign bus_stuck = stuck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stuck_q <= 1'b0;
      step    <= '0;
      cnt     <= '0;
      hp_q    <= HPW'(1);
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          stuck_q <= 1'b0;
          step    <= '0;
          cnt     <= '0;
          hp_q    <= (half_period == '0) ? HPW'(1) : half_period;
        end
      end else if (step_end) begin
        cnt <= '0;
        if (last) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          stuck_q <= ~sda_in;
        end else begin
          step <= step + SW'(1);
        end
      end else begin
        cnt <= cnt + HPW'(1);
      end
    end
  end

  // R6
  done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(step_end && last)) |=> busy);
  // R4
  first_step_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!scl_pull && !sda_pull));
  // R2
  idle_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_pull == eng_scl_oe && sda_pull == eng_sda_oe));
  // R3
  hp_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hp_q));
endmodule

// File: tb/sim_i2c_bus_unstick.sv
module sim_i2c_bus_unstick;
  localparam int CLK_PERIOD = 10;
  localparam int HPW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HPW-1:0] half_period = HPW'(4);
  logic eng_scl_oe = 1'b0, eng_sda_oe = 1'b0, slave_hold = 1'b0;
  wire scl_pull, sda_pull, busy, done, bus_stuck;
  wire sda_in   = ~(sda_pull | slave_hold);
  wire scl_line = ~scl_pull;

  int checks = 0, fails = 0, cycles = 0;

  i2c_bus_unstick #(.HPW(HPW), .PULSES(9)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
    .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
    .bus_stuck(bus_stuck));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_scl(int s);
    return (s < 18) ? (s % 2 == 0) : (s >= 20);
  endfunction

  function automatic bit exp_sda(int s);
    return (s < 18) ? 1'b1 : (s == 18 || s == 21);
  endfunction

  task automatic run_seq(int hp, bit stuck, int glitch, bit noise, int change_hp);
    int h = (hp == 0) ? 1 : hp;
    int n = 0, falls = 0, bad_train = 0, bad_stop = 0, seen_done = 0;
    bit prev_scl = 1'b1;
    @(negedge clk);
    half_period = HPW'(hp);
    slave_hold = stuck;
    eng_scl_oe = noise;
    eng_sda_oe = noise;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3 busy after start", busy, 1);
    check(bus_stuck == 1'b0, "R8 stuck cleared on start", bus_stuck, 0);
    while (busy && n < 5000) begin
      int s = n / h;
      if (!stuck) begin
        if (scl_line != exp_scl(s) || sda_in != exp_sda(s)) begin
          if (s < 18) bad_train++;
          else bad_stop++;
        end
      end
      if (s < 18 && prev_scl && !scl_line) falls++;
      prev_scl = scl_line;
      if (done) seen_done++;
      start = (n == glitch);
      if (change_hp != 0) half_period = HPW'(change_hp);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    check(n == 22 * h, "R3 busy length", n, 22 * h);
    check(falls == 9, "R4 SCL falls in train", falls, 9);
    if (!stuck) begin
      check(bad_train == 0, noise ? "R9 train levels with engine noise" : "R4 train levels",
            bad_train, 0);
      check(bad_stop == 0, "R5 STOP order", bad_stop, 0);
    end
    check(seen_done == 0, "R6 no done while busy", seen_done, 0);
    check(done == 1'b1, "R6 done at busy fall", done, 1);
    check(bus_stuck == stuck, "R8 stuck report", bus_stuck, stuck);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
    if (glitch >= 0) check(busy == 1'b0, "R7 no restart from ignored start", busy, 0);
    check(bus_stuck == stuck, "R8 stuck held", bus_stuck, stuck);
    slave_hold = 1'b0;
    eng_scl_oe = 1'b0;
    eng_sda_oe = 1'b0;
    half_period = HPW'(4);
  endtask

  task automatic test_reset();
    #1;
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(bus_stuck == 1'b0, "R1 stuck in reset", bus_stuck, 0);
    check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 pads follow engine",
          {scl_pull, sda_pull}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_passthrough();
    @(negedge clk);
    eng_scl_oe = 1'b1;
    eng_sda_oe = 1'b0;
    #1;
    check(scl_pull == 1'b1 && sda_pull == 1'b0, "R2 pass scl", {scl_pull, sda_pull}, 2);
    eng_scl_oe = 1'b0;
    eng_sda_oe = 1'b1;
    #1;
    check(scl_pull == 1'b0 && sda_pull == 1'b1, "R2 pass sda", {scl_pull, sda_pull}, 1);
    eng_sda_oe = 1'b0;
  endtask

  initial begin
    test_reset();
    test_passthrough();
    run_seq(4, 1'b0, -1, 1'b0, 0);
    run_seq(1, 1'b0, -1, 1'b0, 0);
    run_seq(0, 1'b0, -1, 1'b0, 0);
    run_seq(3, 1'b0, 5, 1'b0, 0);
    run_seq(2, 1'b0, -1, 1'b1, 7);
    run_seq(3, 1'b1, -1, 1'b0, 0);
    run_seq(2, 1'b0, -1, 1'b0, 0);
    test_passthrough();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule